// File: doc/BRIEF.md
# Serial Port with Deferred Rate Switching

This block is a full-duplex asynchronous serial port that links a host to an on-chip controller. Each frame has a start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity. Both directions take their bit timing from a 16x oversampling divisor. The divisor is derived from the system clock and selected at run time by a rate code. Flow control is hardware and active low. The host holds `rtsN` low to allow transmission. The port drives `ctsN` low while it still has room to receive.

The controller may ask for a new rate while a reply is still waiting to go out. The port holds that request pending. Every byte already accepted for transmission finishes at the old rate. Only then does the transmitter take the new divisor. The receiver follows as soon as it is between frames, so a frame it is part-way through still completes at the old rate. While the change is pending, the port refuses new transmit bytes, so every byte offered after the request goes out at the new rate.

Top module: `defer_rate_uart`

## Requirements
- R1: After reset the port runs at rate code 6 (19200 bit/s), `serOut` is high, `ctsN` is low, `txReady` is high and `rxValid` is low.
- R2: Rate code c (0 to 10) selects 300·2^c bit/s. The divisor is D = round(CLK_HZ / (16·300·2^c)) and every transmitted bit lasts exactly 16·D clock cycles. A frame is a low start bit, 8 data bits least significant first, then a high stop bit. The line idles high.
- R3: A falling edge on `serIn` starts reception, and the start bit is confirmed low at mid-bit. Each data bit is sampled at its centre, least significant first. Received bytes are presented in arrival order on `rxData` with `rxValid`, and each is removed by `rxReady` while `rxValid` is high.
- R4: A byte whose stop bit samples low is delivered with `rxFrameErr` = 1. With a high stop bit, `rxFrameErr` = 0.
- R5: While `rtsN` is high the port starts no new frame on `serOut`. A frame already started completes intact.
- R6: A rate commit (`rateCommit` high for one cycle with `rateCode`) takes effect on the transmitter only once the holding register is empty and the shifter is idle. Bytes accepted before the commit leave at the old rate.
- R7: From the cycle after a commit until the transmitter adopts the new rate, `txReady` is low. Bytes accepted afterwards use the new rate.
- R8: After the switch, the receiver decodes frames at the new rate.
- R9: A frame being received when the switch commits is decoded at the old rate. The receiver adopts the new rate only between frames.
- R10: A commit with a code above 10 is ignored. A second valid commit while one is pending replaces the pending code.
- R11: `ctsN` is high while the receive buffer holds RX_DEPTH−1 or more bytes, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Serial data from the host |
| serOut | output | 1 | Serial data to the host |
| rtsN | input | 1 | Host permits transmission when low |
| ctsN | output | 1 | Port can accept serial data when low |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | `txData` offered |
| txReady | output | 1 | Port accepts the offered byte |
| rxData | output | 8 | Oldest received byte |
| rxFrameErr | output | 1 | Stop-bit error flag of `rxData` |
| rxValid | output | 1 | A received byte is available |
| rxReady | input | 1 | Consumer takes the received byte |
| rateCode | input | 4 | Requested rate code |
| rateCommit | input | 1 | One-cycle strobe that requests `rateCode` |

## Verification
The hardest case is a commit issued while one byte is shifting out and a second waits in the holding register. A design that switched at once would send the second byte, or the tail of the first, at the new rate. A design that did not block new writes would send a later byte at the old rate. A receive frame is also started at the old rate with the commit landing mid-frame; a receiver that adopted the divisor immediately would corrupt that byte. The bench also checks the following:
- An out-of-range code must leave the bit period unchanged.
- Of two quick commits, the later one must win.
- `rtsN` raised mid-frame must not truncate the frame.
- The `ctsN` threshold must move exactly at RX_DEPTH−1 entries.
- A low stop bit must raise the error flag.

// File: rtl/dru_pkg.sv
package dru_pkg;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned RATE_COUNT = 11;
  localparam int unsigned RESET_CODE = 6;
  localparam int unsigned BASE_RATE  = 300;
  localparam int unsigned OVERSAMPLE = 16;

  // strobes from rate control to the datapath
  typedef struct packed {
    logic loadTx;   // transmitter adopts newDiv
    logic loadRx;   // receiver adopts newDiv
    logic blockTx;  // refuse new transmit bytes
  } rate_cmd_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  // rounded 16x divisor for a rate code
  function automatic int unsigned calcDiv(input longint unsigned clkHz, input int unsigned code);
    longint unsigned rate;
    longint unsigned d;
    rate = 64'(BASE_RATE) << code;
    d = (clkHz + rate * 8) / (rate * 64'(OVERSAMPLE));
    if (d == 0) d = 1;
    return 32'(d);
  endfunction
endpackage

// File: rtl/dru_rate_ctrl.sv
module dru_rate_ctrl
  import dru_pkg::*;
#(
  parameter int unsigned CLK_HZ = 49_152_000,
  parameter int unsigned DIV_W  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              rateCommit,
  input  logic              txIdle,
  input  logic              rxIdle,
  output rate_cmd_t         cmd,
  output logic [DIV_W-1:0]  newDiv
);
  logic [DIV_W-1:0] divLut [RATE_COUNT];
  logic pendTx, pendRx, codeOk;

  for (genvar g = 0; g < RATE_COUNT; g++) begin : g_lut
    assign divLut[g] = DIV_W'(calcDiv(64'(CLK_HZ), g));
  end

  assign codeOk      = rateCommit && (rateCode < CODE_W'(RATE_COUNT));
  assign cmd.loadTx  = pendTx && txIdle;
  assign cmd.loadRx  = pendRx && rxIdle;
  assign cmd.blockTx = pendTx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendTx <= 1'b0;
      pendRx <= 1'b0;
      newDiv <= DIV_W'(calcDiv(64'(CLK_HZ), RESET_CODE));
    end else begin
      if (cmd.loadRx) pendRx <= 1'b0;
      if (cmd.loadTx) begin
        pendTx <= 1'b0;
        pendRx <= 1'b1;
      end
      if (codeOk) begin
        pendTx <= 1'b1;
        newDiv <= divLut[rateCode];
      end
    end
  end
endmodule

// File: rtl/dru_datapath.sv
module dru_datapath
  import dru_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DIV_W     = 14,
  parameter int unsigned RX_DEPTH  = 4,
  parameter int unsigned RESET_DIV = 160
) (
  input  logic              clk,
  input  logic              rstN,
  input  rate_cmd_t         cmd,
  input  logic [DIV_W-1:0]  newDiv,
  output logic              txIdle,
  output logic              rxIdle,
  input  logic              serIn,
  output logic              serOut,
  input  logic              rtsN,
  output logic              ctsN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFrameErr,
  output logic              rxValid,
  input  logic              rxReady
);
  localparam int unsigned FRAME_BITS = DATA_W + 2;
  localparam int unsigned SUB_W  = $clog2(OVERSAMPLE);
  localparam int unsigned FBIT_W = $clog2(FRAME_BITS);
  localparam int unsigned DBIT_W = $clog2(DATA_W);
  localparam int unsigned PTR_W  = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int unsigned CNT_W  = $clog2(RX_DEPTH + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);
  localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(OVERSAMPLE / 2 - 1);

  // ---------------- transmitter ----------------
  logic rtsMeta, rtsSync;
  logic holdFull;
  logic [DATA_W-1:0] holdData;
  logic txBusy;
  logic [FRAME_BITS-1:0] txShift;
  logic [DIV_W-1:0] txDiv, txPre;
  logic [SUB_W-1:0] txSub;
  logic [FBIT_W-1:0] txBitCnt;

  assign txReady = !holdFull && !cmd.blockTx;
  assign txIdle  = !holdFull && !txBusy;
  assign serOut  = txBusy ? txShift[0] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtsMeta  <= 1'b1;
      rtsSync  <= 1'b1;
      holdFull <= 1'b0;
      holdData <= '0;
      txBusy   <= 1'b0;
      txShift  <= '1;
      txDiv    <= DIV_W'(RESET_DIV);
      txPre    <= '0;
      txSub    <= '0;
      txBitCnt <= '0;
    end else begin
      rtsMeta <= rtsN;
      rtsSync <= rtsMeta;
      if (cmd.loadTx) txDiv <= newDiv;
      if (txValid && txReady) begin
        holdFull <= 1'b1;
        holdData <= txData;
      end
      if (!txBusy) begin
        if (holdFull && !rtsSync) begin
          txBusy   <= 1'b1;
          txShift  <= {1'b1, holdData, 1'b0};
          holdFull <= 1'b0;
          txPre    <= '0;
          txSub    <= '0;
          txBitCnt <= '0;
        end
      end else if (txPre == txDiv - DIV_W'(1)) begin
        txPre <= '0;
        if (txSub == SUB_LAST) begin
          txSub <= '0;
          if (txBitCnt == FBIT_W'(FRAME_BITS - 1)) begin
            txBusy <= 1'b0;
          end else begin
            txShift  <= {1'b1, txShift[FRAME_BITS-1:1]};
            txBitCnt <= txBitCnt + FBIT_W'(1);
          end
        end else begin
          txSub <= txSub + SUB_W'(1);
        end
      end else begin
        txPre <= txPre + DIV_W'(1);
      end
    end
  end

  AST_TX_RTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && rtsSync) |=> !txBusy);  // R5
  AST_TX_DIV_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |=> $stable(txDiv));  // R6
  AST_TX_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadTx |-> (!txBusy && !holdFull));  // R6
  AST_TX_NO_WRITE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.blockTx && !holdFull && !txBusy) |=> !holdFull);  // R7

  // ---------------- receiver ----------------
  logic inMeta, inSync, inPrev;
  rx_state_e rxState;
  logic [DIV_W-1:0] rxDiv, rxPre;
  logic [SUB_W-1:0] rxSub;
  logic [DBIT_W-1:0] rxBitCnt;
  logic [DATA_W-1:0] rxShift;
  logic rxPush, rxPushFe, rxTick;

  assign rxIdle = (rxState == RX_IDLE);
  assign rxTick = (rxPre == rxDiv - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inMeta   <= 1'b1;
      inSync   <= 1'b1;
      inPrev   <= 1'b1;
      rxState  <= RX_IDLE;
      rxDiv    <= DIV_W'(RESET_DIV);
      rxPre    <= '0;
      rxSub    <= '0;
      rxBitCnt <= '0;
      rxShift  <= '0;
      rxPush   <= 1'b0;
      rxPushFe <= 1'b0;
    end else begin
      inMeta <= serIn;
      inSync <= inMeta;
      inPrev <= inSync;
      rxPush <= 1'b0;
      if (cmd.loadRx) rxDiv <= newDiv;
      if (rxState == RX_IDLE) begin
        if (inPrev && !inSync) begin
          rxState <= RX_START;
          rxPre   <= '0;
          rxSub   <= '0;
        end
      end else if (rxTick) begin
        rxPre <= '0;
        unique case (rxState)
          RX_START: begin
            if (rxSub == SUB_HALF) begin
              rxSub    <= '0;
              rxBitCnt <= '0;
              rxState  <= inSync ? RX_IDLE : RX_DATA;
            end else rxSub <= rxSub + SUB_W'(1);
          end
          RX_DATA: begin
            if (rxSub == SUB_LAST) begin
              rxSub   <= '0;
              rxShift <= {inSync, rxShift[DATA_W-1:1]};
              if (rxBitCnt == DBIT_W'(DATA_W - 1)) rxState <= RX_STOP;
              else rxBitCnt <= rxBitCnt + DBIT_W'(1);
            end else rxSub <= rxSub + SUB_W'(1);
          end
          RX_STOP: begin
            if (rxSub == SUB_LAST) begin
              rxPush   <= 1'b1;
              rxPushFe <= !inSync;
              rxState  <= RX_IDLE;
            end else rxSub <= rxSub + SUB_W'(1);
          end
          default: rxState <= RX_IDLE;
        endcase
      end else begin
        rxPre <= rxPre + DIV_W'(1);
      end
    end
  end

  AST_RX_DIV_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rxState != RX_IDLE) |=> $stable(rxDiv));  // R9

  // ---------------- receive buffer ----------------
  logic [DATA_W:0] fifoMem [RX_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] rxCount;
  logic pushOk, popOk;

  assign pushOk     = rxPush && (rxCount != CNT_W'(RX_DEPTH));
  assign rxValid    = (rxCount != '0);
  assign popOk      = rxValid && rxReady;
  assign rxData     = fifoMem[rdPtr][DATA_W-1:0];
  assign rxFrameErr = fifoMem[rdPtr][DATA_W];
  assign ctsN       = (rxCount >= CNT_W'(RX_DEPTH - 1));

  always_ff @(posedge clk) begin
    if (pushOk) fifoMem[wrPtr] <= {rxPushFe, rxShift};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      rxCount <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == PTR_W'(RX_DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (popOk)  rdPtr <= (rdPtr == PTR_W'(RX_DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({pushOk, popOk})
        2'b10:   rxCount <= rxCount + CNT_W'(1);
        2'b01:   rxCount <= rxCount - CNT_W'(1);
        default: rxCount <= rxCount;
      endcase
    end
  end
endmodule

// File: rtl/defer_rate_uart.sv
module defer_rate_uart
  import dru_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 49_152_000,
  parameter int unsigned RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  output logic              serOut,
  input  logic              rtsN,
  output logic              ctsN,
  input  logic [7:0]        txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [7:0]        rxData,
  output logic              rxFrameErr,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              rateCommit
);
  localparam int unsigned DIV_W     = $clog2(calcDiv(64'(CLK_HZ), 0) + 1);
  localparam int unsigned RESET_DIV = calcDiv(64'(CLK_HZ), RESET_CODE);

  rate_cmd_t cmd;
  logic [DIV_W-1:0] newDiv;
  logic txIdle, rxIdle;

  dru_rate_ctrl #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rateCode(rateCode), .rateCommit(rateCommit),
    .txIdle(txIdle), .rxIdle(rxIdle), .cmd(cmd), .newDiv(newDiv)
  );

  dru_datapath #(.DATA_W(8), .DIV_W(DIV_W), .RX_DEPTH(RX_DEPTH), .RESET_DIV(RESET_DIV)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .newDiv(newDiv),
    .txIdle(txIdle), .rxIdle(rxIdle),
    .serIn(serIn), .serOut(serOut), .rtsN(rtsN), .ctsN(ctsN),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxFrameErr(rxFrameErr), .rxValid(rxValid), .rxReady(rxReady)
  );
endmodule

// File: tb/defer_rate_uart_tb_top.sv
module defer_rate_uart_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 4_915_200;   // divisor for code c is 1024 >> c

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b1, rtsN = 1'b0, txValid = 1'b0, rxReady = 1'b0, rateCommit = 1'b0;
  logic [7:0] txData = '0;
  logic [3:0] rateCode = 4'd6;
  logic serOut, ctsN, txReady, rxFrameErr, rxValid;
  logic [7:0] rxData;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  defer_rate_uart #(.CLK_HZ(TB_CLK_HZ), .RX_DEPTH(4)) dut_i (
    .clk(clk), .rstN(rstN), .serIn(serIn), .serOut(serOut), .rtsN(rtsN), .ctsN(ctsN),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxFrameErr(rxFrameErr), .rxValid(rxValid), .rxReady(rxReady),
    .rateCode(rateCode), .rateCommit(rateCommit)
  );

  function automatic int bitCycles(input int code);
    return 16 * (1024 >> code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushTx(input logic [7:0] b);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData = b;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic commitRate(input logic [3:0] c);
    @(negedge clk);
    rateCode = c;
    rateCommit = 1'b1;
    @(negedge clk);
    rateCommit = 1'b0;
  endtask

  // decodes one frame on serOut; data bit 0 must be 1 so that the low time is the start bit
  task automatic captureFrame(output logic [7:0] b, output int width, output bit stopOk);
    @(negedge clk);
    while (serOut) @(negedge clk);
    width = 0;
    while (!serOut) begin
      width++;
      @(negedge clk);
    end
    repeat (width / 2) @(negedge clk);
    b[0] = serOut;
    for (int i = 1; i < 8; i++) begin
      repeat (width) @(negedge clk);
      b[i] = serOut;
    end
    repeat (width) @(negedge clk);
    stopOk = serOut;
  endtask

  task automatic driveRx(input logic [7:0] b, input int bitCyc, input logic stopBit);
    @(negedge clk);
    serIn = 1'b0;
    repeat (bitCyc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serIn = b[i];
      repeat (bitCyc) @(negedge clk);
    end
    serIn = stopBit;
    repeat (bitCyc) @(negedge clk);
    serIn = 1'b1;
    repeat (bitCyc) @(negedge clk);
  endtask

  task automatic popRx(output logic [7:0] b, output logic fe, output bit got);
    @(negedge clk);
    got = rxValid;
    b = rxData;
    fe = rxFrameErr;
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(serOut == 1'b1, "R1 serOut idle", int'(serOut), 1);
    check(ctsN == 1'b0, "R1 ctsN", int'(ctsN), 0);
    check(txReady == 1'b1, "R1 txReady", int'(txReady), 1);
    check(rxValid == 1'b0, "R1 rxValid", int'(rxValid), 0);
  endtask

  task automatic testTxBasic();
    logic [7:0] b; int w; bit s;
    fork
      captureFrame(b, w, s);
      pushTx(8'hA5);
    join
    check(w == bitCycles(6), "R1 R2 bit period at reset rate", w, bitCycles(6));
    check(b == 8'hA5, "R2 tx data", int'(b), 'hA5);
    check(s, "R2 stop bit high", int'(s), 1);
  endtask

  task automatic testRxBasic();
    logic [7:0] b; logic fe; bit got;
    driveRx(8'h3C, bitCycles(6), 1'b1);
    popRx(b, fe, got);
    check(got, "R3 rx byte present", int'(got), 1);
    check(b == 8'h3C, "R3 rx data", int'(b), 'h3C);
    check(fe == 1'b0, "R4 no frame error", int'(fe), 0);
  endtask

  task automatic testFrameErr();
    logic [7:0] b; logic fe; bit got;
    driveRx(8'h96, bitCycles(6), 1'b0);
    popRx(b, fe, got);
    check(got && b == 8'h96, "R4 rx data with bad stop", int'(b), 'h96);
    check(fe == 1'b1, "R4 frame error flag", int'(fe), 1);
  endtask

  task automatic testRts();
    logic [7:0] b; int w; bit s; bit sawLow;
    rtsN = 1'b1;
    pushTx(8'h81);
    sawLow = 1'b0;
    repeat (1500) begin
      @(negedge clk);
      if (!serOut) sawLow = 1'b1;
    end
    check(!sawLow, "R5 no frame while rtsN high", int'(sawLow), 0);
    rtsN = 1'b0;
    fork
      captureFrame(b, w, s);
      begin
        repeat (900) @(negedge clk);
        rtsN = 1'b1;
      end
    join
    check(b == 8'h81 && s, "R5 frame completes after rtsN rises", int'(b), 'h81);
    rtsN = 1'b0;
  endtask

  task automatic testDeferred();
    logic [7:0] b1, b2, b3; int w1, w2, w3; bit s1, s2, s3;
    logic [7:0] rb; logic fe; bit got;
    bit readyDuringPend;
    readyDuringPend = 1'b1;
    fork
      begin
        captureFrame(b1, w1, s1);
        captureFrame(b2, w2, s2);
        captureFrame(b3, w3, s3);
      end
      begin
        pushTx(8'h55);
        repeat (40) @(negedge clk);
        pushTx(8'hA5);
        repeat (10) @(negedge clk);
        commitRate(4'd10);
        repeat (3) @(negedge clk);
        readyDuringPend = txReady;
        pushTx(8'h35);
      end
    join
    check(readyDuringPend == 1'b0, "R7 txReady low while pending", int'(readyDuringPend), 0);
    check(b1 == 8'h55 && w1 == bitCycles(6), "R6 first queued byte at old rate", w1, bitCycles(6));
    check(b2 == 8'hA5 && w2 == bitCycles(6), "R6 second queued byte at old rate", w2, bitCycles(6));
    check(b3 == 8'h35 && w3 == bitCycles(10), "R7 later byte at new rate", w3, bitCycles(10));
    driveRx(8'hC3, bitCycles(10), 1'b1);
    popRx(rb, fe, got);
    check(got && rb == 8'hC3, "R8 rx at new rate", int'(rb), 'hC3);
  endtask

  task automatic testRxInflight();
    logic [7:0] rb; logic fe; bit got;
    logic [7:0] b; int w; bit s;
    commitRate(4'd6);
    repeat (10) @(negedge clk);
    fork
      driveRx(8'h5A, bitCycles(6), 1'b1);
      begin
        repeat (700) @(negedge clk);
        commitRate(4'd8);
      end
    join
    popRx(rb, fe, got);
    check(got && rb == 8'h5A && !fe, "R9 in-flight rx finished at old rate", int'(rb), 'h5A);
    driveRx(8'h6E, bitCycles(8), 1'b1);
    popRx(rb, fe, got);
    check(got && rb == 8'h6E && !fe, "R8 R9 next rx at new rate", int'(rb), 'h6E);
    fork
      captureFrame(b, w, s);
      pushTx(8'h0F);
    join
    check(b == 8'h0F && w == bitCycles(8), "R8 tx at switched rate", w, bitCycles(8));
  endtask

  task automatic testInvalidAndReplace();
    logic [7:0] b1, b2; int w1, w2; bit s1, s2;
    commitRate(4'd12);
    fork
      captureFrame(b1, w1, s1);
      pushTx(8'h81);
    join
    check(b1 == 8'h81 && w1 == bitCycles(8), "R10 invalid code ignored", w1, bitCycles(8));
    fork
      begin
        captureFrame(b1, w1, s1);
        captureFrame(b2, w2, s2);
      end
      begin
        pushTx(8'h55);
        repeat (20) @(negedge clk);
        commitRate(4'd4);
        commitRate(4'd7);
        pushTx(8'h33);
      end
    join
    check(b1 == 8'h55 && w1 == bitCycles(8), "R10 queued byte at old rate", w1, bitCycles(8));
    check(b2 == 8'h33 && w2 == bitCycles(7), "R10 later commit wins", w2, bitCycles(7));
  endtask

  task automatic testCts();
    logic [7:0] rb; logic fe; bit got;
    driveRx(8'h11, bitCycles(7), 1'b1);
    driveRx(8'h22, bitCycles(7), 1'b1);
    @(negedge clk);
    check(ctsN == 1'b0, "R11 ctsN low at two entries", int'(ctsN), 0);
    driveRx(8'h33, bitCycles(7), 1'b1);
    @(negedge clk);
    check(ctsN == 1'b1, "R11 ctsN high at depth-1", int'(ctsN), 1);
    popRx(rb, fe, got);
    check(got && rb == 8'h11, "R3 order first", int'(rb), 'h11);
    check(ctsN == 1'b0, "R11 ctsN low after pop", int'(ctsN), 0);
    popRx(rb, fe, got);
    check(got && rb == 8'h22, "R3 order second", int'(rb), 'h22);
    popRx(rb, fe, got);
    check(got && rb == 8'h33, "R3 order third", int'(rb), 'h33);
  endtask

  task automatic testSlowRate();
    logic [7:0] b; int w; bit s;
    commitRate(4'd4);
    fork
      captureFrame(b, w, s);
      pushTx(8'h55);
    join
    check(b == 8'h55 && w == bitCycles(4), "R2 bit period at code 4", w, bitCycles(4));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTxBasic();
    testRxBasic();
    testFrameErr();
    testRts();
    testDeferred();
    testRxInflight();
    testInvalidAndReplace();
    testCts();
    testSlowRate();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule